// File: doc/BRIEF.md
# Core Module System Control Register File

This block is the system control register file of a processor core module. Software reaches it over a simple bus that carries a register index, which is the byte offset divided by four. The block holds the main and auxiliary oscillator settings, an SDRAM configuration word and an initialisation word. The two oscillator words accept writes only while a 16-bit unlock key is stored in the lock register.

A control register drives two board outputs: a green status LED and a boot-remap select. Two flag words, one volatile and one non-volatile, are changed through separate write-one-to-set and write-one-to-clear indices. The same scheme applies to the IRQ and FIQ enable masks of a one-bit software interrupt source. A registered core interrupt output reports when the pending level meets either enable mask.

A read-only window returns bytes of a memory serial-presence-detect table. Within that table, an 8-character module tag is set by a parameter. Read data is registered and held until the next read.

Top module: `cmctl_regs`

## Requirements
- R1: The bus index equals the byte offset shifted right by 2. A write to index 5 (lock) stores only bits [15:0] of the write data, and a read returns them zero-extended.
- R2: Writes to index 4 (oscillator) and index 7 (auxiliary oscillator) take effect only while the lock register holds 0xA05F. Otherwise they leave the register unchanged.
- R3: After reset, index 4 reads 0x01000048, index 7 reads 0x0007FEFF, index 8 (SDRAM) reads 0x00011122, index 9 (init) reads 0x00000112, and all other registers read 0. Indices 8 and 9 are plain read/write words.
- R4: Index 3 (control) stores write data bits [7:0] and reads them back; reset value 0. `led_green` follows bit 0. `remap_boot` is 1 (boot memory at address zero) while bit 2 is clear and 0 while it is set.
- R5: Volatile flags: a write to index 12 ORs in the write data and a read of index 12 returns the flags. A write to index 13 clears the bits that are 1 in the write data. Index 13 reads 0.
- R6: Non-volatile flags behave the same way through index 14 (set and read) and index 15 (clear). Index 15 reads 0.
- R7: The IRQ enable mask is set by index 18, read at index 18 and cleared by index 19. The FIQ enable mask is set by index 26, read at index 26 and cleared by index 27. In each case the bits that are 1 in the write data are the ones set or cleared.
- R8: The software interrupt level is one bit. A write to index 20 sets it when write data bit 0 is 1, and a write to index 21 clears it when write data bit 0 is 1. Other write data bits are ignored. Index 20, index 17 (IRQ raw) and index 25 (FIQ raw) all read the level in bit 0.
- R9: Index 16 reads the level AND IRQ enable bit 0, and index 24 reads the level AND FIQ enable bit 0, each in bit 0.
- R10: `core_int` is a register. It equals level AND (IRQ enable bit 0 OR FIQ enable bit 0) as they stood one cycle earlier, so it changes one clock after the write that alters them.
- R11: Indices 64 to 127 (byte offsets 0x100 to 0x1FF) read a zero-extended byte of the SPD table at entry index. Entries 73 to 80 hold the characters of SPD_TAG, most significant byte first. All other entries are 0, and writes to the window are ignored.
- R12: Indices with no register (including 0 to 2, 6, 10, 11, 22, 23, 28 to 35 and 128 and above) read 0, and writes to them change nothing.
- R13: A read strobe (`bus_sel`=1, `bus_wr`=0) loads `bus_rdata` at the next clock edge. `bus_rdata` then holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | IDX_W | Register index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| remap_boot | output | 1 | 1 while boot memory is mapped at address zero |
| led_green | output | 1 | Green status LED |
| core_int | output | 1 | Registered core interrupt request |

## Verification
The bench builds the block with IDX_W = 10 and a custom SPD_TAG. The wider index reaches past the SPD window, so the reads at index 128 and above exercise the unimplemented-index path. The custom tag proves that the table bytes at entries 73 to 80 come from the parameter and not from a fixed pattern. At these values every register, the full SPD window edge (64 and 127) and the tag boundaries (72, 73, 80, 81) can all be reached.

// File: rtl/cmctl_pkg.sv
package cmctl_pkg;

    localparam int DW = 32;

    // register indices (byte offset >> 2)
    localparam int IX_CTRL     = 3;
    localparam int IX_OSC      = 4;
    localparam int IX_LOCK     = 5;
    localparam int IX_AUX      = 7;
    localparam int IX_SDRAM    = 8;
    localparam int IX_INIT     = 9;
    localparam int IX_FLG_SET  = 12;
    localparam int IX_FLG_CLR  = 13;
    localparam int IX_NVF_SET  = 14;
    localparam int IX_NVF_CLR  = 15;
    localparam int IX_IRQ_STAT = 16;
    localparam int IX_IRQ_RAW  = 17;
    localparam int IX_IRQ_SET  = 18;
    localparam int IX_IRQ_CLR  = 19;
    localparam int IX_SWI_SET  = 20;
    localparam int IX_SWI_CLR  = 21;
    localparam int IX_FIQ_STAT = 24;
    localparam int IX_FIQ_RAW  = 25;
    localparam int IX_FIQ_SET  = 26;
    localparam int IX_FIQ_CLR  = 27;

    localparam int SPD_LO      = 64;
    localparam int SPD_HI      = 128;   // exclusive
    localparam int TAG_FIRST   = 73;
    localparam int TAG_LEN     = 8;

    localparam logic [15:0]   UNLOCK_KEY = 16'hA05F;
    localparam logic [DW-1:0] RST_OSC    = 32'h0100_0048;
    localparam logic [DW-1:0] RST_AUX    = 32'h0007_FEFF;
    localparam logic [DW-1:0] RST_SDRAM  = 32'h0001_1122;
    localparam logic [DW-1:0] RST_INIT   = 32'h0000_0112;

    typedef struct packed {
        logic [7:0]    ctrl;
        logic [15:0]   lock;
        logic [DW-1:0] sdram;
        logic [DW-1:0] init;
        logic [DW-1:0] rdata;
    } core_st_t;

    typedef struct packed {
        logic          level;
        logic [DW-1:0] irq_en;
        logic [DW-1:0] fiq_en;
        logic          irq_out;
    } int_st_t;

    // SPD table entry: tag characters at entries 73..80, zero elsewhere
    function automatic logic [7:0] spd_byte(input int idx, input logic [8*TAG_LEN-1:0] tag);
        int k;
        logic [7:0] b;
        b = 8'h00;
        if (idx >= TAG_FIRST && idx < TAG_FIRST + TAG_LEN) begin
            k = idx - TAG_FIRST;
            b = tag[8*(TAG_LEN-1-k) +: 8];
        end
        return b;
    endfunction

endpackage

// File: rtl/cmctl_keyed_reg.sv
module cmctl_keyed_reg #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         unlocked,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_en && unlocked) begin
            val_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST_VAL;
        else        val_q <= val_d;
    end

    assign q = val_q;

    AST_KEY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && unlocked) |=> $stable(q)) else $error("keyed reg changed while locked"); // R2

    AST_KEY_ALLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unlocked) |=> (q == $past(wdata))) else $error("keyed write lost"); // R2

endmodule

// File: rtl/cmctl_setclr.sv
module cmctl_setclr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (set_en)      bits_d = bits_q | wdata;
        else if (clr_en) bits_d = bits_q & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign q = bits_q;

    AST_SET_BITS_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(wdata)) == $past(wdata))) else $error("set bits missing"); // R5

    AST_CLR_BITS_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((q & $past(wdata)) == '0)) else $error("clear bits remain"); // R6

endmodule

// File: rtl/cmctl_irq.sv
module cmctl_irq
    import cmctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_set,
    input  logic          irq_clr,
    input  logic          fiq_set,
    input  logic          fiq_clr,
    input  logic          swi_set,
    input  logic          swi_clr,
    input  logic [DW-1:0] wdata,
    output logic          level,
    output logic [DW-1:0] irq_en,
    output logic [DW-1:0] fiq_en,
    output logic          core_int
);

    int_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (irq_set) st_d.irq_en = st_q.irq_en | wdata;
        if (irq_clr) st_d.irq_en = st_q.irq_en & ~wdata;
        if (fiq_set) st_d.fiq_en = st_q.fiq_en | wdata;
        if (fiq_clr) st_d.fiq_en = st_q.fiq_en & ~wdata;
        if (swi_set && wdata[0]) st_d.level = 1'b1;
        if (swi_clr && wdata[0]) st_d.level = 1'b0;
        // output follows the registered state of the previous cycle
        st_d.irq_out = st_q.level & (st_q.irq_en[0] | st_q.fiq_en[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level    = st_q.level;
    assign irq_en   = st_q.irq_en;
    assign fiq_en   = st_q.fiq_en;
    assign core_int = st_q.irq_out;

    AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (core_int == $past(level & (irq_en[0] | fiq_en[0])))) else $error("core_int timing"); // R10

    AST_SWI_BIT0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((swi_set || swi_clr) && !wdata[0]) |=> $stable(level)) else $error("swi moved on bit>0"); // R8

    AST_SWI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_set && wdata[0]) |=> level) else $error("swi not set"); // R8

endmodule

// File: rtl/cmctl_regs.sv
module cmctl_regs
    import cmctl_pkg::*;
#(
    parameter int                    IDX_W   = 10,
    parameter logic [8*TAG_LEN-1:0]  SPD_TAG = 64'h434D_5245_4753_3031
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             remap_boot,
    output logic             led_green,
    output logic             core_int
);

    localparam int N_FLAG = 2;   // volatile, non-volatile

    logic    wr_stb, rd_stb;
    int      ix;
    core_st_t st_d, st_q;

    assign wr_stb = bus_sel & bus_wr;
    assign rd_stb = bus_sel & ~bus_wr;
    assign ix     = int'(bus_idx);

    function automatic logic hit(input int target);
        return wr_stb && (ix == target);
    endfunction

    // keyed oscillator words
    logic          unlocked;
    logic [DW-1:0] osc_q, aux_q;

    assign unlocked = (st_q.lock == UNLOCK_KEY);

    cmctl_keyed_reg #(.W(DW), .RST_VAL(RST_OSC)) u_osc (
        .clk(clk), .rst_n(rst_n), .wr_en(hit(IX_OSC)), .unlocked(unlocked),
        .wdata(bus_wdata), .q(osc_q));

    cmctl_keyed_reg #(.W(DW), .RST_VAL(RST_AUX)) u_aux (
        .clk(clk), .rst_n(rst_n), .wr_en(hit(IX_AUX)), .unlocked(unlocked),
        .wdata(bus_wdata), .q(aux_q));

    // flag words
    logic [DW-1:0] flag_q [N_FLAG];
    localparam int FLAG_SET_IX [N_FLAG] = '{IX_FLG_SET, IX_NVF_SET};
    localparam int FLAG_CLR_IX [N_FLAG] = '{IX_FLG_CLR, IX_NVF_CLR};

    for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
        cmctl_setclr #(.W(DW)) u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_en(hit(FLAG_SET_IX[g])), .clr_en(hit(FLAG_CLR_IX[g])),
            .wdata(bus_wdata), .q(flag_q[g]));
    end

    // interrupt source
    logic          lvl;
    logic [DW-1:0] irq_en, fiq_en;

    cmctl_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .irq_set(hit(IX_IRQ_SET)), .irq_clr(hit(IX_IRQ_CLR)),
        .fiq_set(hit(IX_FIQ_SET)), .fiq_clr(hit(IX_FIQ_CLR)),
        .swi_set(hit(IX_SWI_SET)), .swi_clr(hit(IX_SWI_CLR)),
        .wdata(bus_wdata), .level(lvl), .irq_en(irq_en), .fiq_en(fiq_en),
        .core_int(core_int));

    // read multiplexer
    logic [DW-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (ix >= SPD_LO && ix < SPD_HI) begin
            rd_val = {24'h0, spd_byte(ix, SPD_TAG)};
        end else begin
            case (ix)
                IX_CTRL:     rd_val = {24'h0, st_q.ctrl};
                IX_OSC:      rd_val = osc_q;
                IX_LOCK:     rd_val = {16'h0, st_q.lock};
                IX_AUX:      rd_val = aux_q;
                IX_SDRAM:    rd_val = st_q.sdram;
                IX_INIT:     rd_val = st_q.init;
                IX_FLG_SET:  rd_val = flag_q[0];
                IX_NVF_SET:  rd_val = flag_q[1];
                IX_IRQ_STAT: rd_val = {31'h0, lvl & irq_en[0]};
                IX_IRQ_RAW:  rd_val = {31'h0, lvl};
                IX_IRQ_SET:  rd_val = irq_en;
                IX_SWI_SET:  rd_val = {31'h0, lvl};
                IX_FIQ_STAT: rd_val = {31'h0, lvl & fiq_en[0]};
                IX_FIQ_RAW:  rd_val = {31'h0, lvl};
                IX_FIQ_SET:  rd_val = fiq_en;
                default:     rd_val = '0;
            endcase
        end
    end

    // local state
    always_comb begin
        st_d = st_q;
        if (hit(IX_CTRL))  st_d.ctrl  = bus_wdata[7:0];
        if (hit(IX_LOCK))  st_d.lock  = bus_wdata[15:0];
        if (hit(IX_SDRAM)) st_d.sdram = bus_wdata;
        if (hit(IX_INIT))  st_d.init  = bus_wdata;
        if (rd_stb)        st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sdram <= RST_SDRAM;
            st_q.init  <= RST_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign led_green  = st_q.ctrl[0];
    assign remap_boot = ~st_q.ctrl[2];

    AST_LOCK_LOW16: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ix == IX_LOCK) |=> (unlocked == ($past(bus_wdata[15:0]) == UNLOCK_KEY))) else $error("lock width"); // R1

    AST_CTRL_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ix == IX_CTRL) |=> (remap_boot == !$past(bus_wdata[2]) && led_green == $past(bus_wdata[0]))) else $error("ctrl outputs"); // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(bus_rdata)) else $error("rdata moved"); // R13

    AST_SPD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && ix >= SPD_LO && ix < SPD_HI) |=> (bus_rdata[31:8] == 24'h0)) else $error("spd width"); // R11

endmodule

// File: tb/cmctl_regs_tb.sv
module cmctl_regs_tb;

    localparam int          IDX_W = 10;
    localparam logic [63:0] TAG   = "CMCTLTB1";

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_sel = 1'b0;
    logic             bus_wr = 1'b0;
    logic [IDX_W-1:0] bus_idx = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             remap_boot, led_green, core_int;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_pend = 1'b0;
    logic [31:0] last_rd = '0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    cmctl_regs #(.IDX_W(IDX_W), .SPD_TAG(TAG)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .remap_boot(remap_boot), .led_green(led_green), .core_int(core_int));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // monitor: a read strobe seen at an edge is compared at the next negedge
    always @(posedge clk) rd_pend <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-empty", bus_rdata, 32'hx);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
            last_rd = bus_rdata;
        end
    end

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = IDX_W'(idx); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = IDX_W'(idx);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R10 reset outputs
        check("R4 led reset", {31'h0, led_green}, 32'h0);
        check("R4 remap reset", {31'h0, remap_boot}, 32'h1);
        check("R10 int reset", {31'h0, core_int}, 32'h0);

        // R3 reset values
        rd(4, 32'h0100_0048, "R3 osc reset");
        rd(7, 32'h0007_FEFF, "R3 aux reset");
        rd(8, 32'h0001_1122, "R3 sdram reset");
        rd(9, 32'h0000_0112, "R3 init reset");
        rd(5, 32'h0, "R3 lock reset");
        rd(12, 32'h0, "R3 flags reset");

        // R2 locked writes ignored
        wr(4, 32'h1234_5678);
        wr(7, 32'h8765_4321);
        rd(4, 32'h0100_0048, "R2 osc locked");
        rd(7, 32'h0007_FEFF, "R2 aux locked");

        // R1 lock keeps low 16 bits
        wr(5, 32'hFFFF_A05F);
        rd(5, 32'h0000_A05F, "R1 lock low16");
        wr(4, 32'hCAFE_F00D);
        wr(7, 32'h0000_0123);
        rd(4, 32'hCAFE_F00D, "R2 osc unlocked");
        rd(7, 32'h0000_0123, "R2 aux unlocked");
        wr(5, 32'h0001_A05E);
        wr(7, 32'h0000_0055);
        rd(7, 32'h0000_0123, "R2 aux relocked");

        // R3 plain words
        wr(8, 32'h0000_ABCD);
        wr(9, 32'h5A5A_0001);
        rd(8, 32'h0000_ABCD, "R3 sdram rw");
        rd(9, 32'h5A5A_0001, "R3 init rw");

        // R4 control
        wr(3, 32'h0000_0005);
        check("R4 led on", {31'h0, led_green}, 32'h1);
        check("R4 remap off", {31'h0, remap_boot}, 32'h0);
        wr(3, 32'h0000_1234);
        check("R4 led off", {31'h0, led_green}, 32'h0);
        check("R4 remap back", {31'h0, remap_boot}, 32'h0);
        rd(3, 32'h0000_0034, "R4 ctrl 8 bits");
        wr(3, 32'h0000_0001);
        check("R4 remap bit2 clear", {31'h0, remap_boot}, 32'h1);

        // R5 volatile flags
        wr(12, 32'h0000_000F);
        rd(12, 32'h0000_000F, "R5 set");
        wr(12, 32'h8000_00F0);
        rd(12, 32'h8000_00FF, "R5 or-in");
        wr(13, 32'h8000_003C);
        rd(12, 32'h0000_00C3, "R5 clear");
        rd(13, 32'h0, "R5 clr index reads 0");

        // R6 non-volatile flags
        wr(14, 32'h0F0F_0000);
        wr(15, 32'h0100_0000);
        rd(14, 32'h0E0F_0000, "R6 nv set/clr");
        rd(15, 32'h0, "R6 clr index reads 0");
        rd(12, 32'h0000_00C3, "R6 volatile untouched");

        // R7 enables
        wr(18, 32'h0000_0080);
        wr(18, 32'h0000_0001);
        rd(18, 32'h0000_0081, "R7 irq set");
        wr(19, 32'h0000_0080);
        rd(18, 32'h0000_0001, "R7 irq clr");
        wr(26, 32'h0000_0006);
        wr(27, 32'h0000_0004);
        rd(26, 32'h0000_0002, "R7 fiq set/clr");

        // R8 only bit 0 of soft interrupt
        wr(20, 32'hFFFF_FFFE);
        rd(20, 32'h0, "R8 bit0 only");
        rd(17, 32'h0, "R8 raw idle");
        check("R10 idle int", {31'h0, core_int}, 32'h0);

        // R10 one-cycle registered output
        wr(20, 32'h0000_0001);
        check("R10 int not yet", {31'h0, core_int}, 32'h0);
        @(negedge clk);
        check("R10 int raised", {31'h0, core_int}, 32'h1);
        rd(20, 32'h1, "R8 level read");
        rd(17, 32'h1, "R8 irq raw");
        rd(25, 32'h1, "R8 fiq raw");
        rd(16, 32'h1, "R9 irq status");
        rd(24, 32'h0, "R9 fiq status masked");

        wr(19, 32'h0000_0001);
        check("R10 int held one cycle", {31'h0, core_int}, 32'h1);
        @(negedge clk);
        check("R10 int dropped", {31'h0, core_int}, 32'h0);
        rd(16, 32'h0, "R9 irq status masked");

        wr(26, 32'h0000_0001);
        @(negedge clk);
        check("R10 int via fiq", {31'h0, core_int}, 32'h1);
        rd(24, 32'h1, "R9 fiq status");
        wr(21, 32'hFFFF_FFFE);
        rd(20, 32'h1, "R8 clr ignores upper bits");
        wr(21, 32'h0000_0001);
        @(negedge clk);
        check("R10 int cleared", {31'h0, core_int}, 32'h0);
        rd(20, 32'h0, "R8 cleared");

        // R11 SPD window
        rd(64, 32'h0, "R11 window start");
        rd(72, 32'h0, "R11 before tag");
        rd(73, {24'h0, TAG[63:56]}, "R11 tag first");
        rd(76, {24'h0, TAG[39:32]}, "R11 tag mid");
        rd(80, {24'h0, TAG[7:0]}, "R11 tag last");
        rd(81, 32'h0, "R11 after tag");
        rd(127, 32'h0, "R11 window end");
        wr(73, 32'h0000_00FF);
        rd(73, {24'h0, TAG[63:56]}, "R11 write ignored");

        // R12 unimplemented indices
        for (int i = 32; i < 36; i++) wr(i, 32'hFFFF_FFFF);
        wr(0, 32'hFFFF_FFFF);
        wr(6, 32'hFFFF_FFFF);
        wr(200, 32'hFFFF_FFFF);
        for (int i = 32; i < 36; i++) rd(i, 32'h0, "R12 voltage idx");
        rd(6, 32'h0, "R12 idx6");
        rd(200, 32'h0, "R12 beyond window");
        rd(12, 32'h0000_00C3, "R12 flags intact");
        rd(14, 32'h0E0F_0000, "R12 nv intact");
        rd(3, 32'h0000_0001, "R12 ctrl intact");
        rd(18, 32'h0000_0000, "R12 irq en intact");
        rd(26, 32'h0000_0003, "R12 fiq en intact");
        check("R12 int quiet", {31'h0, core_int}, 32'h0);

        // R13 read data holds
        rd(9, 32'h5A5A_0001, "R13 read");
        wr(8, 32'h1111_2222);
        repeat (3) @(negedge clk);
        check("R13 hold", bus_rdata, 32'h5A5A_0001);

        repeat (2) @(negedge clk);
        check("scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        finish_run();
    end

endmodule